// File: doc/BRIEF.md
# Window-Constrained Packet Scheduler

This block picks which of N packet streams transmits next. Each stream carries a running loss budget, written as a fraction x'/y' (losses still allowed within a window of y' packets), the original budget x/y, and the deadline of its head packet. A configuration write sets a stream's original budget, copies it into the running budget, and arms the first deadline at the current time plus a per-stream increment. Packet storage and the data path sit outside the block; it only sees one head-valid flag per stream and a time count.

A start pulse launches a scan that visits one stream per clock. Each candidate with a valid head is compared against the best stream found so far. When the scan ends, a done strobe appears together with the winning index and a valid flag. A grant then services the selected stream. If the time has passed that stream's deadline, the block reports either a drop (budget left) or a late send (budget spent). In every case it updates the stream's budget and moves its deadline on by the increment.

Top module: `wcs_sched`

## Requirements
- R1: After reset, sel_valid, done, drop and late are all 0.
- R2: A stream with a lower running fraction x'/y' wins, compared by cross-multiplication; a stream with x'=0 beats one with x'>0.
- R3: When both fractions are non-zero and equal, the earlier deadline wins.
- R4: When both fractions are non-zero and equal and the deadlines match, the smaller x' wins.
- R5: When both streams have x'=0: if both y' are 0 the earlier deadline wins, otherwise the larger y' wins.
- R6: Any tie that is still left goes to the lower stream index. Streams whose head is not valid are never chosen, and with no valid head sel_valid is 0 after the scan.
- R7: An on-time grant (time <= deadline) raises no drop or late, decrements y' when y' > x', and adds the increment to the deadline.
- R8: A late grant (time > deadline, wrap-safe signed difference) with x' > 0 pulses drop for one cycle, decrements x' and y', and advances the deadline by the increment.
- R9: A late grant with x' = 0 pulses late for one cycle, reloads x'/y' from x/y, and advances the deadline by the increment.
- R10: done pulses for one cycle N clocks after the clock edge that samples start. A start that arrives while a scan is running is ignored.
- R11: A configuration write sets x and x' to cfg_x, y and y' to cfg_y, and the deadline to now + cfg_incr.
- R12: When an update leaves both x' and y' at 0, the stream reloads them from x and y.
- R13: A grant has no effect while no valid selection is pending. A selection is consumed by its first grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Stream being configured |
| cfg_x | input | XW | Allowed losses per window |
| cfg_y | input | XW | Window length |
| cfg_incr | input | TW | Deadline increment per packet |
| now | input | TW | Free-running time count |
| head_valid | input | N | One flag per stream: head packet present |
| start | input | 1 | Launch a selection scan |
| tx_grant | input | 1 | Service the current selection |
| sel_idx | output | IW | Chosen stream |
| sel_valid | output | 1 | A selection is pending |
| done | output | 1 | One-cycle scan completion strobe |
| drop | output | 1 | Serviced head was late and is discarded |
| late | output | 1 | Serviced head was late and is sent anyway |

## Verification
The bench goes after the ranking ladder one rule at a time. It uses equal fractions with different deadlines, equal fractions with equal deadlines, and zero-budget pairs with zero and non-zero windows. A comparator with a rule in the wrong order, or a missing rule, picks the other stream. Budget changes are observed through later selections: after a drop, the stream must win on its zero budget. After the window empties, it must reload and lose to a tighter stream. After a late send, the reloaded window must tie a fresh stream so that the lower index wins. A design that did not advance the deadline would report a spurious drop or late on the next prompt grant. A design that acted on a stale second grant would move the deadline on, and the drop the bench expects would not appear.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  parameter int XW = 4;
  parameter int TW = 16;

  typedef struct packed {
    logic [XW-1:0] x;
    logic [XW-1:0] y;
    logic [TW-1:0] dl;
  } wnd_t;
endpackage

// File: rtl/wcs_rank.sv
module wcs_rank import wcs_pkg::*; (
  input  wnd_t inc,
  input  wnd_t cand,
  output logic cand_wins
);
  localparam int PW = 2 * XW;

  logic [PW-1:0] prod_c, prod_i;
  logic [TW-1:0] dl_diff;
  logic          c_earlier, same_dl;

  always_comb begin
    prod_c    = PW'(cand.x) * PW'(inc.y);
    prod_i    = PW'(inc.x) * PW'(cand.y);
    dl_diff   = cand.dl - inc.dl;
    c_earlier = dl_diff[TW-1];
    same_dl   = (dl_diff == '0);
    cand_wins = 1'b0;
    if (inc.x != '0 && cand.x != '0) begin
      if (prod_c < prod_i)                      cand_wins = 1'b1;
      else if (prod_c == prod_i) begin
        if (c_earlier)                          cand_wins = 1'b1;
        else if (same_dl && cand.x < inc.x)     cand_wins = 1'b1;
      end
    end else if (inc.x != '0) begin
      cand_wins = 1'b1;
    end else if (cand.x == '0) begin
      if (inc.y == '0 && cand.y == '0)          cand_wins = c_earlier;
      else                                      cand_wins = (cand.y > inc.y);
    end
  end
endmodule

// File: rtl/wcs_scan.sv
module wcs_scan import wcs_pkg::*; #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          consume,
  input  logic [N-1:0]  head_valid,
  input  wnd_t          cand,
  output logic [IW-1:0] rd_idx,
  output logic          busy,
  output logic          done,
  output logic          sel_valid,
  output logic [IW-1:0] sel_idx
);
  logic [IW-1:0] idx, best_idx;
  logic          best_v;
  wnd_t          best;
  logic          wins, take;

  wcs_rank u_rank (.inc(best), .cand(cand), .cand_wins(wins));

  assign take   = head_valid[idx] && (!best_v || wins);
  assign rd_idx = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      sel_valid <= 1'b0;
      sel_idx   <= '0;
      idx       <= '0;
      best_idx  <= '0;
      best_v    <= 1'b0;
      best      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          idx       <= '0;
          best_v    <= 1'b0;
          sel_valid <= 1'b0;
        end else if (consume) begin
          sel_valid <= 1'b0;
        end
      end else begin
        if (take) begin
          best_idx <= idx;
          best     <= cand;
          best_v   <= 1'b1;
        end
        if (idx == IW'(N - 1)) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          sel_valid <= best_v || take;
          sel_idx   <= take ? idx : best_idx;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end

  p_start_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  p_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  p_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sel_valid);
endmodule

// File: rtl/wcs_table.sv
module wcs_table import wcs_pkg::*; #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [XW-1:0] cfg_x,
  input  logic [XW-1:0] cfg_y,
  input  logic [TW-1:0] cfg_incr,
  input  logic [TW-1:0] now,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [IW-1:0] rd_idx,
  output wnd_t          rd_st,
  output logic          drop_o,
  output logic          late_o
);
  wnd_t          cur [N];
  logic [XW-1:0] ox  [N];
  logic [XW-1:0] oy  [N];
  logic [TW-1:0] inc [N];

  wnd_t          s, nxt;
  logic [TW-1:0] past_by;
  logic          is_late;

  assign rd_st = cur[rd_idx];

  always_comb begin
    s       = cur[upd_idx];
    past_by = now - s.dl;
    is_late = !past_by[TW-1] && (past_by != '0);
    nxt     = s;
    nxt.dl  = s.dl + inc[upd_idx];
    if (!is_late) begin
      if (s.y > s.x) nxt.y = s.y - XW'(1);
    end else if (s.x != '0) begin
      nxt.x = s.x - XW'(1);
      if (s.y != '0) nxt.y = s.y - XW'(1);
    end else begin
      nxt.x = ox[upd_idx];
      nxt.y = oy[upd_idx];
    end
    if (nxt.x == '0 && nxt.y == '0) begin
      nxt.x = ox[upd_idx];
      nxt.y = oy[upd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        cur[i] <= '0;
        ox[i]  <= '0;
        oy[i]  <= '0;
        inc[i] <= '0;
      end
      drop_o <= 1'b0;
      late_o <= 1'b0;
    end else begin
      drop_o <= upd_en && is_late && (s.x != '0);
      late_o <= upd_en && is_late && (s.x == '0);
      if (upd_en) cur[upd_idx] <= nxt;
      if (cfg_we) begin
        cur[cfg_idx] <= '{x: cfg_x, y: cfg_y, dl: now + cfg_incr};
        ox[cfg_idx]  <= cfg_x;
        oy[cfg_idx]  <= cfg_y;
        inc[cfg_idx] <= cfg_incr;
      end
    end
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(drop_o && late_o));
  p_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (drop_o || late_o) |-> $past(upd_en));
endmodule

// File: rtl/wcs_sched.sv
module wcs_sched import wcs_pkg::*; #(
  parameter int N_STREAMS = 4,
  parameter int IW = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [IW-1:0]        cfg_idx,
  input  logic [XW-1:0]        cfg_x,
  input  logic [XW-1:0]        cfg_y,
  input  logic [TW-1:0]        cfg_incr,
  input  logic [TW-1:0]        now,
  input  logic [N_STREAMS-1:0] head_valid,
  input  logic                 start,
  input  logic                 tx_grant,
  output logic [IW-1:0]        sel_idx,
  output logic                 sel_valid,
  output logic                 done,
  output logic                 drop,
  output logic                 late
);
  logic          busy, grant_ok;
  logic [IW-1:0] rd_idx;
  wnd_t          rd_st;

  assign grant_ok = tx_grant && sel_valid && !busy;

  wcs_table #(.N(N_STREAMS), .IW(IW)) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_x(cfg_x), .cfg_y(cfg_y),
    .cfg_incr(cfg_incr), .now(now),
    .upd_en(grant_ok), .upd_idx(sel_idx),
    .rd_idx(rd_idx), .rd_st(rd_st),
    .drop_o(drop), .late_o(late)
  );

  wcs_scan #(.N(N_STREAMS), .IW(IW)) u_scan (
    .clk(clk), .rst(rst), .start(start), .consume(grant_ok),
    .head_valid(head_valid), .cand(rd_st), .rd_idx(rd_idx),
    .busy(busy), .done(done), .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  p_onepulse_r7: assert property (@(posedge clk) disable iff (rst)
    (drop || late) |=> !(drop || late) || $past(grant_ok));
endmodule

// File: tb/wcs_sched_test.sv
module wcs_sched_test;
  localparam int N  = 4;
  localparam int IW = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [3:0]  cfg_x = '0, cfg_y = '0;
  logic [15:0] cfg_incr = '0, tnow = 16'd100;
  logic [3:0]  hv = '0;
  logic        start = 1'b0, tx_grant = 1'b0;
  logic [1:0]  sel_idx;
  logic        sel_valid, done, drop, late;

  int total = 0, bad = 0, cycles = 0;

  always #4 clk = ~clk;

  wcs_sched #(.N_STREAMS(N), .IW(IW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_x(cfg_x),
    .cfg_y(cfg_y), .cfg_incr(cfg_incr), .now(tnow), .head_valid(hv),
    .start(start), .tx_grant(tx_grant), .sel_idx(sel_idx),
    .sel_valid(sel_valid), .done(done), .drop(drop), .late(late)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int i, input int x, input int y, input int inc);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(i); cfg_x = 4'(x); cfg_y = 4'(y); cfg_incr = 16'(inc);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic scan(input logic [3:0] heads, output int idx, output int v, output int lat);
    @(negedge clk);
    hv = heads; start = 1'b1;
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (done) break;
    end
    idx = int'(sel_idx); v = int'(sel_valid);
  endtask

  task automatic grant(output int d, output int l);
    @(negedge clk);
    tx_grant = 1'b1;
    @(negedge clk);
    tx_grant = 1'b0;
    d = int'(drop); l = int'(late);
  endtask

  task automatic t_reset;
    chk("R1 sel_valid", int'(sel_valid), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 drop/late", int'({drop, late}), 0);
  endtask

  task automatic t_latency;
    int seen;
    tnow = 100;
    cfg(0, 1, 2, 10);
    @(negedge clk);
    hv = 4'b0001; start = 1'b1;
    seen = 0;
    for (int k = 1; k <= N + 4; k++) begin
      @(negedge clk);
      start = (k == 1);
      if (done) begin
        seen++;
        chk("R10 done latency", k, N + 1);
      end
    end
    chk("R10 single done despite second start", seen, 1);
  endtask

  task automatic t_fraction;
    int i, v, l;
    tnow = 100;
    cfg(0, 2, 4, 10); cfg(1, 1, 4, 10); cfg(2, 3, 4, 10); cfg(3, 0, 3, 10);
    scan(4'b0111, i, v, l);
    chk("R2 lowest fraction", i, 1);
    scan(4'b1111, i, v, l);
    chk("R2 zero budget beats nonzero", i, 3);
  endtask

  task automatic t_deadline;
    int i, v, l;
    tnow = 100;
    cfg(0, 1, 2, 20); cfg(1, 2, 4, 10);
    scan(4'b0011, i, v, l);
    chk("R3 R11 earlier deadline", i, 1);
    cfg(1, 2, 4, 30);
    scan(4'b0011, i, v, l);
    chk("R3 R11 earlier deadline reversed", i, 0);
  endtask

  task automatic t_numerator;
    int i, v, l;
    tnow = 100;
    cfg(0, 2, 4, 10); cfg(1, 1, 2, 10);
    scan(4'b0011, i, v, l);
    chk("R4 smaller numerator", i, 1);
  endtask

  task automatic t_zero;
    int i, v, l;
    tnow = 100;
    cfg(0, 0, 0, 30); cfg(1, 0, 0, 15);
    scan(4'b0011, i, v, l);
    chk("R5 empty windows earlier deadline", i, 1);
    cfg(0, 0, 2, 10); cfg(1, 0, 5, 10);
    scan(4'b0011, i, v, l);
    chk("R5 larger window", i, 1);
    cfg(0, 0, 5, 10); cfg(1, 0, 2, 10);
    scan(4'b0011, i, v, l);
    chk("R5 larger window reversed", i, 0);
  endtask

  task automatic t_ties;
    int i, v, l;
    tnow = 100;
    cfg(0, 1, 3, 10); cfg(1, 1, 3, 10); cfg(2, 1, 3, 10);
    scan(4'b0110, i, v, l);
    chk("R6 tie lower index", i, 1);
    chk("R6 valid", v, 1);
    scan(4'b0000, i, v, l);
    chk("R6 no valid head", v, 0);
  endtask

  task automatic t_ontime;
    int i, v, l, d, lt;
    tnow = 100;
    cfg(0, 1, 3, 10); cfg(1, 1, 3, 10);
    scan(4'b0011, i, v, l);
    chk("R7 first pick", i, 0);
    grant(d, lt);
    chk("R7 on-time no drop/late", d * 2 + lt, 0);
    scan(4'b0011, i, v, l);
    chk("R7 window shrank so other wins", i, 1);
  endtask

  task automatic t_drop;
    int i, v, l, d, lt;
    tnow = 100;
    cfg(0, 1, 2, 10);
    scan(4'b0001, i, v, l);
    tnow = 115;
    grant(d, lt);
    chk("R8 drop pulse", d, 1);
    chk("R8 no late", lt, 0);
    cfg(1, 1, 4, 50);
    scan(4'b0011, i, v, l);
    chk("R8 budget spent so stream wins", i, 0);
    tnow = 118;
    grant(d, lt);
    chk("R8 deadline advanced", d * 2 + lt, 0);
    scan(4'b0011, i, v, l);
    chk("R12 window reloaded", i, 1);
  endtask

  task automatic t_late;
    int i, v, l, d, lt;
    tnow = 200;
    cfg(2, 0, 3, 10);
    scan(4'b0100, i, v, l);
    tnow = 205;
    grant(d, lt);
    chk("R7 on-time zero budget", d * 2 + lt, 0);
    tnow = 225;
    scan(4'b0100, i, v, l);
    grant(d, lt);
    chk("R9 late pulse", lt, 1);
    chk("R9 no drop", d, 0);
    cfg(3, 0, 3, 100);
    scan(4'b1100, i, v, l);
    chk("R9 window reloaded", i, 2);
    tnow = 228;
    grant(d, lt);
    chk("R9 deadline advanced", d * 2 + lt, 0);
  endtask

  task automatic t_stale;
    int i, v, l, d, lt;
    tnow = 300;
    cfg(0, 2, 3, 10);
    scan(4'b0001, i, v, l);
    tnow = 305;
    grant(d, lt);
    grant(d, lt);
    chk("R13 stale grant silent", d * 2 + lt, 0);
    scan(4'b0001, i, v, l);
    tnow = 322;
    grant(d, lt);
    chk("R13 stale grant left deadline", d, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_fraction();
    t_deadline();
    t_numerator();
    t_zero();
    t_ties();
    t_ontime();
    t_drop();
    t_late();
    t_stale();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule